// File: doc/BRIEF.md
# Register-Driven Configuration Request Issuer

This block lets software, working through a small register bus, make an endpoint function issue one configuration read or one configuration write to another function, and then pick up the answer. Software sets up the target and the kind of access in two setup registers. A write to the data register launches the request. Software then polls a status word until the completion has arrived.

The request leaves the block as a set of header fields with a valid/ready handshake. The requester identity is not programmable. It is built from a bus number that the function captured earlier, with the device/function byte fixed at 0x04 (device 0, function 4) and the tag fixed at zero. A returning completion is accepted only when its destination ID equals that identity. The block always treats an accepted completion as one that carries data, and makes no format check on it.

Software can give up on a lost completion by writing a one to the DONE position of the status word. The block then discards every completion until the next launch.

Top module: `cfg_req_issuer`

## Requirements
- R1: After reset the status word reads 0, the data register reads 0, both setup registers read 0, and `req_valid` is low.
- R2: A write to the data register (address 2) while the block is idle raises `req_valid` on the next cycle. The request carries the following fields:
  - the target ID from setup bits [15:0];
  - the register number from setup bits [25:16];
  - the byte enables from mode bits [7:4];
  - the direction from mode bit 0 (1 means write);
  - the written value as the payload.
- R3: Every request carries requester ID {bus, 8'h04}, where bus is `cap_bus` sampled at launch, and carries tag 0.
- R4: While `req_valid` is high and `req_ready` is low, every request field holds still. `req_valid` falls in the cycle after it is accepted.
- R5: While BUSY (status bit 0) is set, or while a request still waits for acceptance, a write to the data register is ignored. It emits no request and leaves the data register unchanged.
- R6: A completion whose `cpl_dest_id` equals the current requester ID, arriving while BUSY, has three effects on the next cycle:
  - it sets DONE (status bit 1);
  - it clears BUSY;
  - it places `cpl_status` in status bits [6:4] (0 successful, 1 unsupported request, 2 retry, 4 completer abort).
  A completion with any other destination ID changes nothing.
- R7: The completion payload enters the data register only when the operation was a read and the code is 0. In every other case the data register keeps its value.
- R8: Writing status with bit 1 set clears BUSY on the next cycle. It leaves DONE unchanged. Every completion after it is dropped until a new launch.
- R9: A launch clears DONE and the status code on the next cycle and sets BUSY.
- R10: When an abort write and a matching completion fall in the same cycle, the abort wins. DONE stays clear, and neither the status code nor the data register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 setup, 1 mode, 2 data, 3 status |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Contents of the selected register (combinational) |
| cap_bus | input | 8 | Captured bus number of the function |
| req_valid | output | 1 | Request header valid |
| req_ready | input | 1 | Request header accepted |
| req_is_write | output | 1 | 1 for a configuration write |
| req_requester_id | output | 16 | Requester ID |
| req_tag | output | 8 | Tag, always 0 |
| req_target_id | output | 16 | Bus/device/function of the target |
| req_reg_num | output | 10 | Dword register number |
| req_byte_en | output | 4 | First dword byte enables |
| req_data | output | 32 | Write payload |
| cpl_valid | input | 1 | Completion header valid |
| cpl_dest_id | input | 16 | Completion destination ID |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion payload |

## Verification
The abort path and the completion-match path act on the same state, and both can fall in one clock. The bench provokes this by raising the status-register abort write and a matching completion on the same falling edge, after a read launch has been accepted. It then reads the status word and the data register. They must show BUSY and DONE clear, the old status code, and the launch payload, not the completion payload. A later matching completion must also leave them untouched.

// File: rtl/cri_pkg.sv
package cri_pkg;
    localparam int DW     = 32;
    localparam int BUSW   = 8;
    localparam int IDW    = 16;
    localparam int REGW   = 10;
    localparam int BEW    = 4;
    localparam int STW    = 3;
    localparam int TAGW   = 8;
    localparam int ADDRW  = 2;

    localparam int FN_W   = IDW - BUSW;
    localparam logic [FN_W-1:0] SYN_DEVFN = FN_W'(8'h04);
    localparam logic [TAGW-1:0] FIXED_TAG = '0;

    localparam int ST_BUSY_BIT = 0;
    localparam int ST_DONE_BIT = 1;
    localparam int ST_CODE_LSB = 4;

    localparam int TGT_LSB  = 0;
    localparam int RN_LSB   = IDW;
    localparam int MODE_WR_BIT = 0;
    localparam int MODE_BE_LSB = 4;

    localparam logic [STW-1:0] CS_OK = '0;

    typedef enum logic [ADDRW-1:0] {
        RA_SETUP = 2'd0,
        RA_MODE  = 2'd1,
        RA_DATA  = 2'd2,
        RA_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            is_write;
        logic [IDW-1:0]  target;
        logic [REGW-1:0] regnum;
        logic [BEW-1:0]  be;
    } setup_t;

    typedef struct packed {
        logic            is_write;
        logic [IDW-1:0]  rid;
        logic [TAGW-1:0] tag;
        logic [IDW-1:0]  target;
        logic [REGW-1:0] regnum;
        logic [BEW-1:0]  be;
        logic [DW-1:0]   data;
    } req_hdr_t;

    typedef struct packed {
        logic            valid;
        logic [IDW-1:0]  dest;
        logic [STW-1:0]  code;
        logic [DW-1:0]   data;
    } cpl_t;

    function automatic logic [IDW-1:0] make_rid(input logic [BUSW-1:0] bus);
        return {bus, SYN_DEVFN};
    endfunction

    function automatic logic [DW-1:0] pack_status(input logic busy, input logic done,
                                                  input logic [STW-1:0] code);
        logic [DW-1:0] w;
        w = '0;
        w[ST_BUSY_BIT] = busy;
        w[ST_DONE_BIT] = done;
        w[ST_CODE_LSB +: STW] = code;
        return w;
    endfunction
endpackage

// File: rtl/cri_regs.sv
module cri_regs
    import cri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    data_q,
    input  logic             busy,
    input  logic             done,
    input  logic [STW-1:0]   code,
    output setup_t           setup,
    output logic             data_wr,
    output logic             abort,
    output logic [DW-1:0]    rdata
);
    setup_t setup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
        end else if (wr_en) begin
            if (addr == RA_SETUP) begin
                setup_q.target <= wdata[TGT_LSB +: IDW];
                setup_q.regnum <= wdata[RN_LSB +: REGW];
            end else if (addr == RA_MODE) begin
                setup_q.is_write <= wdata[MODE_WR_BIT];
                setup_q.be       <= wdata[MODE_BE_LSB +: BEW];
            end
        end
    end

    assign setup   = setup_q;
    assign data_wr = wr_en && (addr == RA_DATA);
    assign abort   = wr_en && (addr == RA_STAT) && wdata[ST_DONE_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SETUP: begin
                rdata[TGT_LSB +: IDW] = setup_q.target;
                rdata[RN_LSB +: REGW] = setup_q.regnum;
            end
            RA_MODE: begin
                rdata[MODE_WR_BIT]        = setup_q.is_write;
                rdata[MODE_BE_LSB +: BEW] = setup_q.be;
            end
            RA_DATA: rdata = data_q;
            default: rdata = pack_status(busy, done, code);
        endcase
    end
endmodule

// File: rtl/cri_txn.sv
module cri_txn
    import cri_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            data_wr,
    input  logic [DW-1:0]   wval,
    input  logic            abort,
    input  logic            op_is_write,
    input  logic [BUSW-1:0] cap_bus,
    input  logic            req_pending,
    input  cpl_t            cpl,
    output logic            issue,
    output logic [IDW-1:0]  issue_rid,
    output logic            busy,
    output logic            done,
    output logic [STW-1:0]  code,
    output logic [DW-1:0]   data_q
);
    logic           busy_q, done_q, wr_q;
    logic [STW-1:0] code_q;
    logic [DW-1:0]  dat_q;
    logic [IDW-1:0] rid_q;
    logic           hit;

    assign issue     = data_wr && !busy_q && !req_pending;
    assign issue_rid = make_rid(cap_bus);
    assign hit       = cpl.valid && busy_q && (cpl.dest == rid_q) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            code_q <= '0;
            dat_q  <= '0;
            rid_q  <= '0;
        end else if (issue) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            code_q <= '0;
            dat_q  <= wval;
            rid_q  <= issue_rid;
            wr_q   <= op_is_write;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (hit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            code_q <= cpl.code;
            if (!wr_q && cpl.code == CS_OK)
                dat_q <= cpl.data;
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign code   = code_q;
    assign data_q = dat_q;
endmodule

// File: rtl/cri_req_out.sv
module cri_req_out
    import cri_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  req_hdr_t hdr_in,
    input  logic     ready,
    output logic     valid,
    output req_hdr_t hdr
);
    logic     v_q;
    req_hdr_t h_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            h_q <= '0;
        end else if (load) begin
            v_q <= 1'b1;
            h_q <= hdr_in;
        end else if (v_q && ready) begin
            v_q <= 1'b0;
        end
    end

    assign valid = v_q;
    assign hdr   = h_q;
endmodule

// File: rtl/cfg_req_issuer.sv
module cfg_req_issuer
    import cri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [ADDRW-1:0] reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [BUSW-1:0]  cap_bus,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_is_write,
    output logic [IDW-1:0]   req_requester_id,
    output logic [TAGW-1:0]  req_tag,
    output logic [IDW-1:0]   req_target_id,
    output logic [REGW-1:0]  req_reg_num,
    output logic [BEW-1:0]   req_byte_en,
    output logic [DW-1:0]    req_data,
    input  logic             cpl_valid,
    input  logic [IDW-1:0]   cpl_dest_id,
    input  logic [STW-1:0]   cpl_status,
    input  logic [DW-1:0]    cpl_data
);
    setup_t         setup;
    logic           data_wr, abort, issue;
    logic           busy_w, done_w;
    logic [STW-1:0] code_w;
    logic [DW-1:0]  data_w;
    logic [IDW-1:0] issue_rid;
    req_hdr_t       hdr_next, hdr_w;
    cpl_t           cpl_w;

    assign cpl_w = '{valid: cpl_valid, dest: cpl_dest_id, code: cpl_status, data: cpl_data};

    cri_regs regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .data_q(data_w), .busy(busy_w), .done(done_w), .code(code_w),
        .setup(setup), .data_wr(data_wr), .abort(abort), .rdata(reg_rdata)
    );

    cri_txn txn_i (
        .clk(clk), .rst(rst), .data_wr(data_wr), .wval(reg_wdata), .abort(abort),
        .op_is_write(setup.is_write), .cap_bus(cap_bus), .req_pending(req_valid),
        .cpl(cpl_w), .issue(issue), .issue_rid(issue_rid), .busy(busy_w),
        .done(done_w), .code(code_w), .data_q(data_w)
    );

    always_comb begin
        hdr_next          = '0;
        hdr_next.is_write = setup.is_write;
        hdr_next.rid      = issue_rid;
        hdr_next.tag      = FIXED_TAG;
        hdr_next.target   = setup.target;
        hdr_next.regnum   = setup.regnum;
        hdr_next.be       = setup.be;
        hdr_next.data     = reg_wdata;
    end

    cri_req_out out_i (
        .clk(clk), .rst(rst), .load(issue), .hdr_in(hdr_next), .ready(req_ready),
        .valid(req_valid), .hdr(hdr_w)
    );

    assign req_is_write     = hdr_w.is_write;
    assign req_requester_id = hdr_w.rid;
    assign req_tag          = hdr_w.tag;
    assign req_target_id    = hdr_w.target;
    assign req_reg_num      = hdr_w.regnum;
    assign req_byte_en      = hdr_w.be;
    assign req_data         = hdr_w.data;
endmodule

// File: rtl/cri_checker.sv
module cri_checker
    import cri_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [ADDRW-1:0] reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDW-1:0]   req_requester_id,
    input logic [TAGW-1:0]  req_tag,
    input logic [IDW-1:0]   req_target_id,
    input logic [DW-1:0]    req_data,
    input logic             busy,
    input logic             done
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_target_id)
                                    && $stable(req_data) && $stable(req_requester_id));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !busy |=> !req_valid);

    // R3
    req_tag_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_tag == '0 && req_requester_id[FN_W-1:0] == SYN_DEVFN);

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_addr == RA_DATA && busy && !req_valid |=> !req_valid);

    // R8
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_addr == RA_STAT && reg_wdata[ST_DONE_BIT] |=> !busy);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);
endmodule

bind cfg_req_issuer cri_checker chk_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_requester_id(req_requester_id), .req_tag(req_tag),
    .req_target_id(req_target_id), .req_data(req_data),
    .busy(busy_w), .done(done_w)
);

// File: tb/cfg_req_issuer_tb_top.sv
module cfg_req_issuer_tb_top;
    import cri_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0] cap_bus = 8'h00;
    logic req_valid, req_ready = 1'b1, req_is_write;
    logic [15:0] req_requester_id, req_target_id;
    logic [7:0] req_tag;
    logic [9:0] req_reg_num;
    logic [3:0] req_byte_en;
    logic [31:0] req_data;
    logic cpl_valid = 1'b0;
    logic [15:0] cpl_dest_id = '0;
    logic [2:0] cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfg_req_issuer dut_i (.*);

    typedef struct packed {
        logic        wr;
        logic [15:0] tgt;
        logic [9:0]  rn;
        logic [3:0]  be;
        logic [31:0] pay;
        logic [7:0]  bus;
        logic [2:0]  st;
        logic [31:0] cd;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{1'b0, 16'h0108, 10'h010, 4'hF, 32'h0000_0000, 8'h05, 3'd0, 32'hCAFE_0001},
        '{1'b1, 16'h2200, 10'h3FF, 4'h3, 32'h1234_5678, 8'hA0, 3'd0, 32'hDEAD_BEEF},
        '{1'b0, 16'hFFFF, 10'h001, 4'h1, 32'h0BAD_0BAD, 8'h01, 3'd1, 32'h5555_AAAA},
        '{1'b0, 16'h0310, 10'h200, 4'hC, 32'h0000_00FF, 8'hFF, 3'd4, 32'h7777_0000}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stw(input bit b, input bit d, input logic [2:0] s);
        return {25'b0, s, 2'b0, d, b};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cpl(input logic [15:0] dst, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_dest_id = dst; cpl_status = s; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic setup(input bit w, input logic [15:0] t, input logic [9:0] r,
                         input logic [3:0] be);
        wr(2'd0, {6'b0, r, t});
        wr(2'd1, {24'b0, be, 3'b0, w});
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] rid;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd3, v); chk(v == 32'h0, "R1 status", v, 0);
        rd(2'd2, v); chk(v == 32'h0, "R1 data", v, 0);
        rd(2'd0, v); chk(v == 32'h0, "R1 setup", v, 0);
        chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);

        foreach (VECS[i]) begin
            vec_t t = VECS[i];
            logic [31:0] exp;
            cap_bus = t.bus;
            setup(t.wr, t.tgt, t.rn, t.be);
            wr(2'd2, t.pay);
            // R2 header fields
            chk(req_valid && req_is_write == t.wr && req_target_id == t.tgt &&
                req_reg_num == t.rn && req_byte_en == t.be && req_data == t.pay,
                "R2 request fields", {req_valid, req_is_write, req_target_id, req_data},
                {1'b1, t.wr, t.tgt, t.pay});
            // R3 requester id and tag
            chk(req_requester_id == {t.bus, 8'h04} && req_tag == 8'h00, "R3 rid/tag",
                {req_requester_id, req_tag}, {t.bus, 8'h04, 8'h00});
            @(negedge clk);
            chk(!req_valid, "R4 drop after accept", req_valid, 0);
            cpl({t.bus, 8'h04}, t.st, t.cd);
            rd(2'd3, v);
            chk(v == stw(0, 1, t.st), "R6 status after completion", v, stw(0, 1, t.st));
            exp = (!t.wr && t.st == 3'd0) ? t.cd : t.pay;
            rd(2'd2, v);
            chk(v == exp, "R7 data register", v, exp);
        end

        // R9 new launch clears done and code (previous op left code 4)
        cap_bus = 8'h33; rid = {8'h33, 8'h04};
        setup(1'b0, 16'h0400, 10'h004, 4'hF);
        wr(2'd2, 32'h0000_1111);
        rd(2'd3, v); chk(v == stw(1, 0, 0), "R9 launch clears", v, stw(1, 0, 0));
        // R5 data write while busy is ignored
        wr(2'd2, 32'h9999_9999);
        chk(!req_valid, "R5 no second request", req_valid, 0);
        rd(2'd2, v); chk(v == 32'h0000_1111, "R5 data unchanged", v, 32'h0000_1111);
        // R6 wrong destination ignored
        cpl(16'h3305, 3'd0, 32'hAAAA_AAAA);
        rd(2'd3, v); chk(v == stw(1, 0, 0), "R6 mismatch ignored", v, stw(1, 0, 0));
        cpl(rid, 3'd0, 32'hBBBB_BBBB);
        rd(2'd2, v); chk(v == 32'hBBBB_BBBB, "R6 match after mismatch", v, 32'hBBBB_BBBB);

        // R4 stall holds fields
        req_ready = 1'b0;
        wr(2'd2, 32'h0000_2222);
        repeat (3) @(negedge clk);
        chk(req_valid && req_data == 32'h0000_2222 && req_requester_id == rid,
            "R4 held under stall", {req_valid, req_data}, {1'b1, 32'h0000_2222});
        req_ready = 1'b1;
        @(negedge clk);
        chk(!req_valid, "R4 released", req_valid, 0);

        // R8 abort then late completion dropped
        wr(2'd3, 32'h2);
        rd(2'd3, v); chk(v == stw(0, 0, 0), "R8 abort clears busy", v, stw(0, 0, 0));
        cpl(rid, 3'd0, 32'hCCCC_CCCC);
        rd(2'd3, v); chk(v == stw(0, 0, 0), "R8 late completion dropped", v, stw(0, 0, 0));
        rd(2'd2, v); chk(v == 32'h0000_2222, "R8 data kept", v, 32'h0000_2222);

        // R10 abort and matching completion in the same cycle
        wr(2'd2, 32'h0000_3333);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h2;
        cpl_valid = 1'b1; cpl_dest_id = rid; cpl_status = 3'd0; cpl_data = 32'hDDDD_DDDD;
        @(negedge clk);
        reg_wr_en = 1'b0; cpl_valid = 1'b0;
        rd(2'd3, v); chk(v == stw(0, 0, 0), "R10 abort wins status", v, stw(0, 0, 0));
        rd(2'd2, v); chk(v == 32'h0000_3333, "R10 abort wins data", v, 32'h0000_3333);
        cpl(rid, 3'd0, 32'hEEEE_EEEE);
        rd(2'd2, v); chk(v == 32'h0000_3333, "R10 later completion dropped", v, 32'h0000_3333);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule